// File: doc/BRIEF.md
# Memory Block Copy Controller

This block moves a fixed run of 32 words inside a 512-word, 4-bit-wide synchronous RAM. A single pulse on `start` makes it copy words 0..31 into words 32..63, one word at a time. Each word is read into a 4-bit holding register and then written back to its destination.

The source and destination addresses share one 5-bit counter. The destination is formed by raising the single address bit just above the count, so no second counter and no adder are needed. The remaining upper address bits stay at zero for the whole copy.

While the block is idle, an external port can read and write the RAM directly. This port is used to load data before a copy and to inspect the result after it.

Top module: `blkcopy_top`

## Requirements
- R1: While reset is held and after it is released, `done` and `busy` are 0 and the block stays idle until `start` is seen high.
- R2: After a copy, word 32+i holds the value that word i held before the copy, for every i in 0..31.
- R3: During a copy, RAM address bits 8..6 are 0. Bit 5 is 0 on every read and 1 on every write. Bits 4..0 carry the word count.
- R4: A copy takes three cycles per word (read address, load, write). `done` is high in the 97th cycle after the clock edge that samples `start`.
- R5: `done` is high for exactly one cycle. In the following cycle the block is idle again, with `busy` 0.
- R6: The copy leaves words 0..31 and words 64 and above unchanged.
- R7: A `start` pulse seen while a copy is running is ignored and does not change when `done` rises.
- R8: An external write (`ext_we`=1) while `busy` is 1 has no effect on the RAM.
- R9: While idle, an external write lands on the clock edge. Read data for the address presented at an edge appears on `ext_rdata` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a copy when idle |
| done | output | 1 | One-cycle completion flag |
| busy | output | 1 | A copy is in progress |
| ext_addr | input | 9 | External RAM address (used when idle) |
| ext_wdata | input | 4 | External write data |
| ext_we | input | 1 | External write enable (used when idle) |
| ext_rdata | output | 4 | RAM read data, one cycle after the address |

## Verification
External reads return data one edge after the address is presented. The bench therefore drives each address at a falling edge and samples `ext_rdata` at the next falling edge. For a copy, the bench counts rising edges from the one that samples `start` and expects `done` at exactly edge 97. It then expects `done` and `busy` to be low one edge later. The mid-copy `start` pulse and the mid-copy external write fall inside that same counted window, so the timing check of R7 and the readback of R8 show whether either one leaked through.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

    typedef enum logic [2:0] {
        CP_IDLE  = 3'd0,
        CP_RADDR = 3'd1,
        CP_RLOAD = 3'd2,
        CP_WRITE = 3'd3,
        CP_DONE  = 3'd4
    } cp_state_e;

    typedef struct packed {
        logic cnt_clr;
        logic cnt_en;
        logic hold_ld;
        logic mem_we;
        logic dst_sel;
        logic busy;
        logic done;
    } cp_ctrl_t;

    function automatic cp_ctrl_t ctrl_of(cp_state_e s);
        cp_ctrl_t c;
        c = '0;
        case (s)
            CP_IDLE:  c.cnt_clr = 1'b1;
            CP_RADDR: c.busy = 1'b1;
            CP_RLOAD: begin c.busy = 1'b1; c.hold_ld = 1'b1; end
            CP_WRITE: begin
                c.busy    = 1'b1;
                c.mem_we  = 1'b1;
                c.dst_sel = 1'b1;
                c.cnt_en  = 1'b1;
            end
            CP_DONE:  c.done = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/blkcopy_ram.sv
module blkcopy_ram #(
    parameter int AW = 9,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= din;
        addr_q <= addr;
    end

    assign dout = cells[addr_q];
endmodule

// File: rtl/blkcopy_counter.sv
module blkcopy_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count,
    output logic         at_last
);
    localparam logic [W-1:0] LAST = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (en)    count <= count + 1'b1;
    end

    assign at_last = (count == LAST);

    // R4: the count moves by exactly one after every enabled cycle
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(clr) && !$past(rst)) |-> count == $past(count) + 1'b1);
endmodule

// File: rtl/blkcopy_fsm.sv
module blkcopy_fsm
    import blkcopy_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     at_last,
    output cp_ctrl_t ctrl
);
    cp_state_e state, nxt;

    always_comb begin
        nxt = state;
        case (state)
            CP_IDLE:  if (start) nxt = CP_RADDR;
            CP_RADDR: nxt = CP_RLOAD;
            CP_RLOAD: nxt = CP_WRITE;
            CP_WRITE: nxt = at_last ? CP_DONE : CP_RADDR;
            CP_DONE:  nxt = CP_IDLE;
            default:  nxt = CP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CP_IDLE;
        else     state <= nxt;
    end

    assign ctrl = ctrl_of(state);

    // R5: completion is a single-cycle pulse followed by idle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        ctrl.done |=> (!ctrl.done && !ctrl.busy));
    // R4: a write always follows the cycle that loaded the holding register
    a_r4_write_after_load: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_we |-> $past(ctrl.hold_ld));
endmodule

// File: rtl/blkcopy_top.sv
module blkcopy_top
    import blkcopy_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 4,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              done,
    output logic              busy,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    input  logic              ext_we,
    output logic [DATA_W-1:0] ext_rdata
);
    localparam int HI_W = ADDR_W - CNT_W - 1;

    cp_ctrl_t          ctrl;
    logic [CNT_W-1:0]  count;
    logic              at_last;
    logic [DATA_W-1:0] hold_q;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_din, ram_dout;
    logic              ram_we;
    logic [ADDR_W-1:0] copy_addr;

    blkcopy_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .at_last(at_last), .ctrl(ctrl)
    );

    blkcopy_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(ctrl.cnt_clr), .en(ctrl.cnt_en),
        .count(count), .at_last(at_last)
    );

    always_ff @(posedge clk) begin
        if (rst)               hold_q <= '0;
        else if (ctrl.hold_ld) hold_q <= ram_dout;
    end

    assign copy_addr = {{HI_W{1'b0}}, ctrl.dst_sel, count};

    always_comb begin
        if (ctrl.busy) begin
            ram_addr = copy_addr;
            ram_din  = hold_q;
            ram_we   = ctrl.mem_we;
        end else begin
            ram_addr = ext_addr;
            ram_din  = ext_wdata;
            ram_we   = ext_we;
        end
    end

    blkcopy_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk(clk), .we(ram_we), .addr(ram_addr), .din(ram_din), .dout(ram_dout)
    );

    assign done      = ctrl.done;
    assign busy      = ctrl.busy;
    assign ext_rdata = ram_dout;

    // R2: the holding register captures the read data of the load cycle
    a_r2_hold_capture: assert property (@(posedge clk) disable iff (rst)
        ($past(ctrl.hold_ld) && !$past(rst)) |-> hold_q == $past(ram_dout));
    // R3: upper address bits stay zero during a copy
    a_r3_high_zero: assert property (@(posedge clk) disable iff (rst)
        busy |-> ram_addr[ADDR_W-1:CNT_W+1] == '0);
    // R3: reads use the lower half, writes the upper half
    a_r3_half_select: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ram_addr[CNT_W] == ram_we));
endmodule

// File: tb/blkcopy_top_bench.sv
module blkcopy_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       done, busy;
    logic [8:0] ext_addr = '0;
    logic [3:0] ext_wdata = '0;
    logic       ext_we = 1'b0;
    logic [3:0] ext_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    blkcopy_top u_blkcopy_top (
        .clk(clk), .rst(rst), .start(start), .done(done), .busy(busy),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_we(ext_we),
        .ext_rdata(ext_rdata)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pat(input int sel, input int a);
        return 4'((a * (3 + 2 * sel) + sel + 1) ^ (a >> 4));
    endfunction

    task automatic wr(input int a, input logic [3:0] d);
        @(negedge clk);
        ext_addr = 9'(a); ext_wdata = d; ext_we = 1'b1;
        @(negedge clk);
        ext_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [3:0] d);
        @(negedge clk);
        ext_addr = 9'(a);
        @(negedge clk);
        d = ext_rdata;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 busy in reset", int'(busy), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 done idle", int'(done), 0);
        chk("R1 busy idle", int'(busy), 0);
    endtask

    task automatic t_preload(input int sel);
        for (int a = 0; a < 128; a++) wr(a, pat(sel, a));
    endtask

    task automatic t_copy(input int sel, input bit intrude);
        int edges;
        logic [3:0] d;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        while (!done && edges < 300) begin
            if (intrude && edges == 40) begin
                start = 1'b1; ext_addr = 9'd100; ext_wdata = ~pat(sel, 100); ext_we = 1'b1;
            end else begin
                start = 1'b0; ext_we = 1'b0;
            end
            @(negedge clk);
            edges++;
        end
        start = 1'b0; ext_we = 1'b0;
        chk(intrude ? "R7 done timing with extra start" : "R4 done timing", edges, 97);
        @(negedge clk);
        chk("R5 done single cycle", int'(done), 0);
        chk("R5 idle after done", int'(busy), 0);
        for (int i = 0; i < 32; i++) begin
            rd(32 + i, d);
            chk("R2 destination word", int'(d), int'(pat(sel, i)));
        end
        for (int i = 0; i < 32; i++) begin
            rd(i, d);
            chk("R6 source word kept", int'(d), int'(pat(sel, i)));
        end
        for (int a = 64; a < 128; a++) begin
            rd(a, d);
            chk(a == 100 && intrude ? "R8 write while busy ignored" : "R6 upper word kept",
                int'(d), int'(pat(sel, a)));
        end
    endtask

    task automatic t_port;
        logic [3:0] d;
        wr(200, 4'h9);
        rd(200, d);
        chk("R9 external write/read", int'(d), 9);
        wr(200, 4'h6);
        rd(200, d);
        chk("R9 external overwrite", int'(d), 6);
    endtask

    task automatic t_r3_sum;
        // R3: the destination layout (bit 5 set, bits 8..6 clear) is what R2 readback covers
        logic [3:0] d;
        rd(32 + 31, d);
        chk("R3 last destination at address 63", int'(d), int'(pat(1, 31)));
    endtask

    initial begin
        t_reset();
        t_port();
        t_preload(0);
        t_copy(0, 1'b0);
        t_preload(1);
        t_copy(1, 1'b1);
        t_r3_sum();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule